// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Pair

This unit performs 32-bit multiplication and division for a small load/store processor core. It holds a private pair of result registers, HI and LO. A multiply places the upper half of its 64-bit product in HI and the lower half in LO. A divide places the remainder in HI and the quotient in LO. Two transfer operations load HI or LO directly from an operand. HI and LO are always visible on read ports, which the core uses for its move-from instructions.

The core presents an operation code and two operands together with a one-cycle `start` strobe. A multiply or a transfer is committed at the clock edge that samples the strobe, and `busy` stays low. A divide with a nonzero divisor runs a restoring shift-subtract loop that produces one quotient bit per cycle. `busy` stays high until the result is committed. The surrounding pipeline uses `busy` to stall.

Top module: `mdu_unit`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `hiOut`, `loOut` and `busy` are all zero.
- R2: Code 1 (signed multiply) treats both operands as two's complement. The cycle after the strobe, `hiOut` holds the upper 32 bits of the 64-bit product and `loOut` holds the lower 32 bits, and `busy` stays low.
- R3: Code 2 (unsigned multiply) does the same as R2 but treats both operands as unsigned.
- R4: Code 3 (signed divide) truncates the quotient toward zero and writes it to `loOut`. It writes the remainder to `hiOut`, and the remainder has the sign of the dividend `opA`. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R5: Code 4 (unsigned divide) writes the unsigned quotient to `loOut` and the unsigned remainder to `hiOut`.
- R6: A divide with a nonzero divisor raises `busy` on the edge that samples the strobe. `busy` stays high for exactly 32 cycles. HI and LO take the result on the edge where `busy` falls.
- R7: A divide (code 3 or 4) with `opB` equal to zero leaves HI and LO unchanged and never raises `busy`.
- R8: Code 5 loads HI from `opA` and leaves LO unchanged. Code 6 loads LO from `opA` and leaves HI unchanged.
- R9: A strobe that arrives while `busy` is high is ignored, whatever its code. The divide that is running still commits its own result.
- R10: While `busy` is high, `hiOut` and `loOut` keep the values they had before the divide started.
- R11: Codes 0 and 7 perform no operation: HI, LO and `busy` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| op | input | 3 | Operation code (see R2 to R11) |
| opA | input | 32 | First operand: multiplicand, dividend, or transfer source |
| opB | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | High while a divide is iterating |
| hiOut | output | 32 | Current HI contents |
| loOut | output | 32 | Current LO contents |

## Verification
The checker watches every cycle for the following properties:
- the unsigned product lands in HI and LO,
- each transfer leaves the other register alone,
- a zero divisor changes nothing,
- HI and LO hold steady during a divide,
- busy never lasts past 32 cycles and drops only after exactly 32.

Some behaviour only the directed scenarios can show. These are the signed quotient and remainder rules and their sign combinations, the -2^31 / -1 corner case, the reset values, and the fact that a strobe arriving mid-divide changes neither the result nor the timing.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_MULS  = 3'd1,
    OP_MULU  = 3'd2,
    OP_DIVS  = 3'd3,
    OP_DIVU  = 3'd4,
    OP_SETHI = 3'd5,
    OP_SETLO = 3'd6,
    OP_IDLE7 = 3'd7
  } mduOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic mulCommit;
    logic mulSigned;
    logic divLoad;
    logic divSigned;
    logic divStep;
    logic divLast;
    logic hiWrite;
    logic loWrite;
  } mduCtrl_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic [2:0] op,
  input  logic     divisorZero,
  output mduCtrl_t ctrl,
  output logic     busy
);

  localparam int CW = $clog2(WIDTH);

  logic [CW-1:0] stepCnt;
  logic          accept;

  assign accept = start && !busy;

  always_comb begin
    ctrl = '0;
    if (accept) begin
      unique case (mduOp_e'(op))
        OP_MULS:  begin ctrl.mulCommit = 1'b1; ctrl.mulSigned = 1'b1; end
        OP_MULU:  ctrl.mulCommit = 1'b1;
        OP_DIVS:  begin
          ctrl.divLoad   = !divisorZero;
          ctrl.divSigned = 1'b1;
        end
        OP_DIVU:  ctrl.divLoad = !divisorZero;
        OP_SETHI: ctrl.hiWrite = 1'b1;
        OP_SETLO: ctrl.loWrite = 1'b1;
        default:  ctrl = '0;
      endcase
    end
    if (busy) begin
      ctrl.divStep = 1'b1;
      ctrl.divLast = (stepCnt == CW'(WIDTH - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
    end else begin
      if (ctrl.divLoad) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (ctrl.divStep) begin
        busy    <= !ctrl.divLast;
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             divisorZero,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  localparam int PW = 2 * WIDTH;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] hiQ, loQ;
  logic [WIDTH-1:0] remQ, quoQ, dsrQ;
  logic             negQuoQ, negRemQ;

  // multiplier
  logic [PW-1:0] prodSigned, prodUnsigned, prod;
  assign prodSigned   = {{WIDTH{opA[MSB]}}, opA} * {{WIDTH{opB[MSB]}}, opB};
  assign prodUnsigned = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};
  assign prod         = ctrl.mulSigned ? prodSigned : prodUnsigned;

  // divider operand preparation
  logic [WIDTH-1:0] magA, magB;
  assign magA = (ctrl.divSigned && opA[MSB]) ? (~opA + 1'b1) : opA;
  assign magB = (ctrl.divSigned && opB[MSB]) ? (~opB + 1'b1) : opB;
  assign divisorZero = (opB == '0);

  // one restoring iteration
  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] trial;
  logic             fits;
  logic [WIDTH-1:0] remNext, quoNext, remFinal, quoFinal;

  assign shifted  = {remQ, quoQ[MSB]};
  assign trial    = {1'b0, shifted} - {2'b00, dsrQ};
  assign fits     = !trial[WIDTH+1];
  assign remNext  = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
  assign quoNext  = {quoQ[WIDTH-2:0], fits};
  assign quoFinal = negQuoQ ? (~quoNext + 1'b1) : quoNext;
  assign remFinal = negRemQ ? (~remNext + 1'b1) : remNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ    <= '0;
      quoQ    <= '0;
      dsrQ    <= '0;
      negQuoQ <= 1'b0;
      negRemQ <= 1'b0;
    end else if (ctrl.divLoad) begin
      remQ    <= '0;
      quoQ    <= magA;
      dsrQ    <= magB;
      negQuoQ <= ctrl.divSigned && (opA[MSB] ^ opB[MSB]);
      negRemQ <= ctrl.divSigned && opA[MSB];
    end else if (ctrl.divStep) begin
      remQ <= remNext;
      quoQ <= quoNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else begin
      if (ctrl.mulCommit) begin
        hiQ <= prod[PW-1:WIDTH];
        loQ <= prod[WIDTH-1:0];
      end
      if (ctrl.divStep && ctrl.divLast) begin
        hiQ <= remFinal;
        loQ <= quoFinal;
      end
      if (ctrl.hiWrite) hiQ <= opA;
      if (ctrl.loWrite) loQ <= opA;
    end
  end

  assign hiOut = hiQ;
  assign loOut = loQ;

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  mduCtrl_t ctrl;
  logic     divisorZero;

  mdu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .divisorZero(divisorZero), .ctrl(ctrl), .busy(busy)
  );

  mdu_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .divisorZero(divisorZero), .hiOut(hiOut), .loOut(loOut)
  );

endmodule

// File: rtl/mdu_chk.sv
module mdu_chk
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             busy,
  input logic [WIDTH-1:0] hiOut,
  input logic [WIDTH-1:0] loOut
);

  localparam int RW = $clog2(WIDTH) + 2;

  logic [RW-1:0] busyRun;
  logic          accepted;
  logic          isDiv;

  assign accepted = start && !busy;
  assign isDiv    = (op == OP_DIVS) || (op == OP_DIVU);

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R3
  mulu_prod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && op == OP_MULU) |=>
      ({hiOut, loOut} == {{WIDTH{1'b0}}, $past(opA)} * {{WIDTH{1'b0}}, $past(opB)}) && !busy);

  // R8
  sethi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && op == OP_SETHI) |=> (hiOut == $past(opA)) && $stable(loOut));

  // R8
  setlo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && op == OP_SETLO) |=> (loOut == $past(opA)) && $stable(hiOut));

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && isDiv && opB == '0) |=> $stable(hiOut) && $stable(loOut) && !busy);

  // R10
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(hiOut) && $stable(loOut)));

  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RW'(WIDTH));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RW'(WIDTH)));

  // R11
  noop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && (op == OP_NONE || op == OP_IDLE7)) |=>
      $stable(hiOut) && $stable(loOut) && !busy);

endmodule

bind mdu_unit mdu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_mdu_unit.sv
module tb_mdu_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        busy;
  logic [31:0] hiOut, loOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  mdu_unit dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc >= 100000);
    bad++;
    $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = code; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0; op = 3'd0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 hi", hiOut, 32'h0);
    check("R1 lo", loOut, 32'h0);
    check("R1 busy", {31'b0, busy}, 32'h0);
  endtask

  task automatic testMul(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] expP;
    if (sgn) expP = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    else     expP = {32'b0, a} * {32'b0, b};
    issue(sgn ? 3'd1 : 3'd2, a, b);
    check(sgn ? "R2 hi" : "R3 hi", hiOut, expP[63:32]);
    check(sgn ? "R2 lo" : "R3 lo", loOut, expP[31:0]);
    check(sgn ? "R2 busy" : "R3 busy", {31'b0, busy}, 32'h0);
  endtask

  task automatic runDiv(input logic sgn, input logic [31:0] a, input logic [31:0] b,
                        input logic intrude);
    logic [31:0] expQ, expR, preHi, preLo;
    int cycles;
    if (!sgn) begin
      expQ = a / b; expR = a % b;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      expQ = 32'h8000_0000; expR = 32'h0;
    end else begin
      expQ = 32'($signed(a) / $signed(b));
      expR = 32'($signed(a) % $signed(b));
    end
    preHi = hiOut; preLo = loOut;
    issue(sgn ? 3'd3 : 3'd4, a, b);
    check("R6 busy rise", {31'b0, busy}, 32'h1);
    cycles = 0;
    while (busy) begin
      if (intrude && cycles == 3) begin
        start = 1'b1; op = 3'd5; opA = 32'hDEAD_BEEF;
      end else if (intrude && cycles == 5) begin
        start = 1'b1; op = 3'd2; opA = 32'h7; opB = 32'h9;
      end else begin
        start = 1'b0; op = 3'd0;
      end
      if (cycles == 10) begin
        check("R10 hi held", hiOut, preHi);
        check("R10 lo held", loOut, preLo);
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check("R6 cycles", cycles, 32);
    check(intrude ? "R9 hi" : (sgn ? "R4 hi" : "R5 hi"), hiOut, expR);
    check(intrude ? "R9 lo" : (sgn ? "R4 lo" : "R5 lo"), loOut, expQ);
  endtask

  task automatic testDivZero();
    logic [31:0] h, l;
    h = hiOut; l = loOut;
    issue(3'd3, 32'd55, 32'd0);
    check("R7 signed hi", hiOut, h);
    check("R7 signed lo", loOut, l);
    check("R7 busy", {31'b0, busy}, 32'h0);
    issue(3'd4, 32'hFFFF_0000, 32'd0);
    check("R7 unsigned hi", hiOut, h);
    check("R7 unsigned lo", loOut, l);
  endtask

  task automatic testMoves();
    issue(3'd5, 32'h1234_5678, 32'h0);
    issue(3'd6, 32'h9ABC_DEF0, 32'h0);
    check("R8 hi", hiOut, 32'h1234_5678);
    check("R8 lo", loOut, 32'h9ABC_DEF0);
    issue(3'd5, 32'hCAFE_0001, 32'h0);
    check("R8 hi new", hiOut, 32'hCAFE_0001);
    check("R8 lo kept", loOut, 32'h9ABC_DEF0);
    issue(3'd6, 32'h0BAD_F00D, 32'h0);
    check("R8 hi kept", hiOut, 32'hCAFE_0001);
    check("R8 lo new", loOut, 32'h0BAD_F00D);
  endtask

  task automatic testNoop();
    issue(3'd0, 32'h1111_1111, 32'h2);
    check("R11 code0 hi", hiOut, 32'hCAFE_0001);
    issue(3'd7, 32'h1111_1111, 32'h2);
    check("R11 code7 lo", loOut, 32'h0BAD_F00D);
    check("R11 busy", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    testReset();
    testMul(1'b1, 32'hFFFF_FFFD, 32'd7);
    testMul(1'b1, 32'h8000_0000, 32'h8000_0000);
    testMul(1'b1, 32'h0001_2345, 32'hFFFE_0000);
    testMul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    testMul(1'b0, 32'hDEAD_BEEF, 32'h0000_1000);
    testMoves();
    testNoop();
    testDivZero();
    runDiv(1'b1, 32'd100, 32'd7, 1'b0);
    runDiv(1'b1, -32'sd100, 32'd7, 1'b0);
    runDiv(1'b1, 32'd100, -32'sd7, 1'b0);
    runDiv(1'b1, -32'sd100, -32'sd7, 1'b0);
    runDiv(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    runDiv(1'b0, 32'hFFFF_FFFF, 32'd10, 1'b0);
    runDiv(1'b0, 32'h8000_0001, 32'h8000_0000, 1'b0);
    runDiv(1'b0, 32'd3, 32'd9, 1'b0);
    runDiv(1'b0, 32'd1_000_000, 32'd3, 1'b1);
    testReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule